// File: doc/BRIEF.md
# Paged memory read engine with CRC-8 insertion

This block serves the memory-read function commands of a single-wire slave once the slave has been selected. The byte layer below it delivers received bytes and signals when each outgoing byte has been taken. The engine takes a command byte and a two-byte target address, low byte first, then high byte. It first returns a CRC-8 of the command and the address. It then streams array bytes, inserts CRC-8 bytes at the boundaries each command defines, and returns all-ones once the readable range has been used up.

There are two arrays: a 160-byte data array of five 32-byte pages and an 8-byte status array. Both are read through one synchronous port. The port has one cycle of read latency and a select line that picks the status array. The engine fetches each array byte one byte ahead, so the next byte is always ready when the serialiser asks for it. A bus reset returns the engine to waiting for the next selection.

Top module: `paged_rd_crc`

## Requirements
- R1: After rst_ni or a bus_reset_i cycle, tx_valid_o and mem_rd_o are low, and the engine waits for cmd_start_i before it accepts a command byte.
- R2: The first outgoing byte is the CRC-8 of the command byte, the filtered low address byte and the filtered high address byte, in that order. The CRC uses polynomial x^8+x^5+x^4+1, starts at 00h, and shifts each byte in LSB first.
- R3: Command F0h streams data bytes from the filtered address through 007Fh, then one CRC-8 of every data byte it sent, then FFh for every later slot.
- R4: Command C3h sends a CRC-8 after every byte whose low five address bits are all ones. That CRC covers the bytes sent since the start or since the previous CRC. The stream then continues at the next page, and after the CRC of page 3 (address 007Fh) every later slot returns FFh.
- R5: Command 65h uses the full 16-bit address. It streams data through 009Fh, then a CRC-8, then FFh. A start address of 00A0h or higher, including any nonzero high byte, returns FFh from the first data slot and sends no CRC.
- R6: Command AAh reads the status array (mem_status_o = 1) from the filtered address through 0007h, then sends a CRC-8, then FFh. A filtered start address from 0008h to 007Fh returns FFh from the first data slot.
- R7: For F0h, C3h and AAh, the target address is ANDed with 007Fh before it is used, including for the header CRC. For example, 0085h behaves exactly like 0005h.
- R8: tx_byte_o holds its value until tx_ack_i is seen while tx_valid_o is high. Each array read is issued as a single cycle pulse one byte ahead of use, and array reads stay inside the selected array (data at most 009Fh, status at most 0007h). tx_ack_i must be at least four cycles apart.
- R9: Any other command byte leaves tx_valid_o and mem_rd_o low until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_reset_i | input | 1 | Bus reset seen on the wire; clears all state |
| cmd_start_i | input | 1 | Selection done; the next received byte is the command |
| rx_valid_i | input | 1 | Received byte valid (one cycle) |
| rx_byte_i | input | 8 | Received byte |
| tx_ack_i | input | 1 | Serialiser has taken tx_byte_o |
| tx_valid_o | output | 1 | Engine is in its send phase |
| tx_byte_o | output | 8 | Byte to transmit next |
| mem_rd_o | output | 1 | Array read strobe |
| mem_status_o | output | 1 | 1 selects the status array, 0 the data array |
| mem_addr_o | output | 8 | Array read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after mem_rd_o |

## Verification
The bench starts reads a few bytes before each boundary: the end of page 3 for F0h, a page crossing for C3h, and the end of the array for 65h. A design with the end address off by one would emit the CRC one byte early or late. A design that keeps the running CRC across page CRCs would give wrong CRCs after the first page. It drives addresses with bit 7 or the high byte set, and in the reserved range. A design that filters the wrong commands would read the wrong bytes, send a wrong header CRC, or read beyond the array instead of returning ones. A bus reset in mid-stream and an unknown command check that nothing stays active.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam logic [7:0] CMD_MEM  = 8'hF0;
  localparam logic [7:0] CMD_PAGE = 8'hC3;
  localparam logic [7:0] CMD_ALL  = 8'h65;
  localparam logic [7:0] CMD_STAT = 8'hAA;

  typedef enum logic [1:0] {CK_MEM, CK_PAGE, CK_ALL, CK_STAT} cmd_e;
  typedef enum logic [1:0] {IT_DATA, IT_CRC, IT_ONES} item_e;

  // reflected x^8+x^5+x^4+1, LSB first
  function automatic logic [7:0] crc8_upd(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 8'h8C;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/prd_cmd_dec.sv
module prd_cmd_dec
  import prd_pkg::*;
(
  input  logic [7:0] cmd_i,
  output logic       known_o,
  output cmd_e       kind_o
);
  always_comb begin
    known_o = 1'b1;
    kind_o  = CK_MEM;
    case (cmd_i)
      CMD_MEM:  kind_o = CK_MEM;
      CMD_PAGE: kind_o = CK_PAGE;
      CMD_ALL:  kind_o = CK_ALL;
      CMD_STAT: kind_o = CK_STAT;
      default:  known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/prd_next_item.sv
module prd_next_item
  import prd_pkg::*;
#(
  parameter int AW        = 8,
  parameter int PG_BITS   = 5,
  parameter int LEG_LAST  = 127,
  parameter int DATA_LAST = 159,
  parameter int STAT_LAST = 7
) (
  input  cmd_e          kind_i,
  input  item_e         cur_it_i,
  input  logic [AW-1:0] cur_addr_i,
  output item_e         nxt_it_o,
  output logic [AW-1:0] nxt_addr_o
);
  localparam logic [AW-1:0] LegA  = AW'(LEG_LAST);
  localparam logic [AW-1:0] DataA = AW'(DATA_LAST);
  localparam logic [AW-1:0] StatA = AW'(STAT_LAST);

  logic at_end;

  always_comb begin
    case (kind_i)
      CK_MEM:  at_end = (cur_addr_i == LegA);
      CK_PAGE: at_end = &cur_addr_i[PG_BITS-1:0];
      CK_ALL:  at_end = (cur_addr_i == DataA);
      default: at_end = (cur_addr_i == StatA);
    endcase
  end

  always_comb begin
    nxt_it_o   = IT_ONES;
    nxt_addr_o = cur_addr_i;
    case (cur_it_i)
      IT_DATA: begin
        if (at_end) nxt_it_o = IT_CRC;
        else begin
          nxt_it_o   = IT_DATA;
          nxt_addr_o = cur_addr_i + AW'(1);
        end
      end
      IT_CRC: begin
        if (kind_i == CK_PAGE && cur_addr_i != LegA) begin
          nxt_it_o   = IT_DATA;
          nxt_addr_o = cur_addr_i + AW'(1);
        end
      end
      default: nxt_it_o = IT_ONES;
    endcase
  end
endmodule

// File: rtl/paged_rd_crc.sv
module paged_rd_crc
  import prd_pkg::*;
#(
  parameter int PAGE_BYTES   = 32,
  parameter int DATA_PAGES   = 5,
  parameter int LEGACY_PAGES = 4,
  parameter int STAT_BYTES   = 8,
  parameter int AW           = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_reset_i,
  input  logic          cmd_start_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_byte_i,
  input  logic          tx_ack_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_byte_o,
  output logic          mem_rd_o,
  output logic          mem_status_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i
);
  localparam int PG_BITS   = $clog2(PAGE_BYTES);
  localparam int LEG_LAST  = PAGE_BYTES * LEGACY_PAGES - 1;
  localparam int DATA_LAST = PAGE_BYTES * DATA_PAGES - 1;
  localparam int STAT_LAST = STAT_BYTES - 1;
  localparam logic [AW-1:0] LegMask = AW'(LEG_LAST);
  localparam logic [AW-1:0] DataA   = AW'(DATA_LAST);
  localparam logic [AW-1:0] StatA   = AW'(STAT_LAST);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_TA1, S_TA2, S_SEND, S_DEAD} st_e;

  st_e           st_q;
  cmd_e          kind_q, dec_kind;
  item_e         it_q, nxt_it;
  logic          dec_known;
  logic [AW-1:0] ta1_q, addr_q, nxt_addr, t1;
  logic [7:0]    crc_q, tx_q, pf_q, t2;
  logic          rd_q, pend_q, masked, reserved, consumed;

  prd_cmd_dec u_dec (
    .cmd_i   (rx_byte_i),
    .known_o (dec_known),
    .kind_o  (dec_kind)
  );

  prd_next_item #(
    .AW(AW), .PG_BITS(PG_BITS), .LEG_LAST(LEG_LAST),
    .DATA_LAST(DATA_LAST), .STAT_LAST(STAT_LAST)
  ) u_nxt (
    .kind_i     (kind_q),
    .cur_it_i   (it_q),
    .cur_addr_i (addr_q),
    .nxt_it_o   (nxt_it),
    .nxt_addr_o (nxt_addr)
  );

  assign masked   = (kind_q != CK_ALL);
  assign t1       = masked ? (rx_byte_i[AW-1:0] & LegMask) : rx_byte_i[AW-1:0];
  assign t2       = masked ? 8'h00 : rx_byte_i;
  assign reserved = (kind_q == CK_ALL)  ? (rx_byte_i != 8'h00 || ta1_q > DataA) :
                    (kind_q == CK_STAT) ? (ta1_q > StatA) : 1'b0;
  assign consumed = (st_q == S_SEND) && tx_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      kind_q <= CK_MEM;
      it_q   <= IT_ONES;
      ta1_q  <= '0;
      addr_q <= '0;
      crc_q  <= '0;
      tx_q   <= '1;
      pf_q   <= '0;
      rd_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (bus_reset_i) begin
      st_q   <= S_IDLE;
      it_q   <= IT_ONES;
      crc_q  <= '0;
      tx_q   <= '1;
      rd_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      rd_q   <= 1'b0;
      pend_q <= rd_q;
      if (pend_q) pf_q <= mem_rdata_i;
      case (st_q)
        S_IDLE: if (cmd_start_i) st_q <= S_CMD;
        S_CMD: if (rx_valid_i) begin
          if (dec_known) begin
            kind_q <= dec_kind;
            crc_q  <= crc8_upd(8'h00, rx_byte_i);
            st_q   <= S_TA1;
          end else st_q <= S_DEAD;
        end
        S_TA1: if (rx_valid_i) begin
          ta1_q <= t1;
          crc_q <= crc8_upd(crc_q, 8'(t1));
          st_q  <= S_TA2;
        end
        S_TA2: if (rx_valid_i) begin
          tx_q   <= crc8_upd(crc_q, t2);
          crc_q  <= '0;
          it_q   <= reserved ? IT_ONES : IT_DATA;
          addr_q <= ta1_q;
          rd_q   <= !reserved;
          st_q   <= S_SEND;
        end
        S_SEND: if (consumed) begin
          case (it_q)
            IT_DATA: begin
              tx_q  <= pf_q;
              crc_q <= crc8_upd(crc_q, pf_q);
            end
            IT_CRC: begin
              tx_q  <= crc_q;
              crc_q <= '0;
            end
            default: tx_q <= '1;
          endcase
          it_q   <= nxt_it;
          addr_q <= nxt_addr;
          rd_q   <= (nxt_it == IT_DATA);
        end
        default: ;
      endcase
    end
  end

  assign tx_valid_o   = (st_q == S_SEND);
  assign tx_byte_o    = tx_q;
  assign mem_rd_o     = rd_q;
  assign mem_addr_o   = addr_q;
  assign mem_status_o = (kind_q == CK_STAT);
endmodule

// File: rtl/prd_checker.sv
module prd_checker #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_reset_i,
  input logic          tx_ack_i,
  input logic          tx_valid_o,
  input logic [7:0]    tx_byte_o,
  input logic          mem_rd_o,
  input logic          mem_status_o,
  input logic [AW-1:0] mem_addr_o
);
  // R1
  a_r1_bus_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (!tx_valid_o && !mem_rd_o));

  // R8
  a_r8_hold_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ack_i && !bus_reset_i) |=> (tx_valid_o && $stable(tx_byte_o)));

  a_r8_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  // R5
  a_r5_data_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !mem_status_o) |-> (mem_addr_o <= AW'(159)));

  // R6
  a_r6_stat_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && mem_status_o) |-> (mem_addr_o <= AW'(7)));
endmodule

bind paged_rd_crc prd_checker #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_reset_i  (bus_reset_i),
  .tx_ack_i     (tx_ack_i),
  .tx_valid_o   (tx_valid_o),
  .tx_byte_o    (tx_byte_o),
  .mem_rd_o     (mem_rd_o),
  .mem_status_o (mem_status_o),
  .mem_addr_o   (mem_addr_o)
);

// File: tb/paged_rd_crc_tb.sv
module paged_rd_crc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0, cmd_start = 1'b0, rx_valid = 1'b0, tx_ack = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       tx_valid, mem_rd, mem_status;
  logic [7:0] tx_byte, mem_addr, mem_rdata;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "";
  logic [7:0] expq[$];

  always #4 clk = ~clk;

  paged_rd_crc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset), .cmd_start_i(cmd_start),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .tx_ack_i(tx_ack),
    .tx_valid_o(tx_valid), .tx_byte_o(tx_byte), .mem_rd_o(mem_rd),
    .mem_status_o(mem_status), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] dat_f(int a);
    logic [7:0] v;
    v = 8'(a * 29 + 7);
    return v ^ {3'(a), 5'b0};
  endfunction

  function automatic logic [7:0] st_f(int a);
    return 8'hC0 + 8'(a * 3);
  endfunction

  always_ff @(posedge clk)
    if (mem_rd) mem_rdata <= mem_status ? st_f(int'(mem_addr)) : dat_f(int'(mem_addr));

  // shift register model of x^8+x^5+x^4+1, LSB first
  function automatic logic [7:0] crc_ref(logic [7:0] s, logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = s[0] ^ b[i];
      s = {fb, s[7:1]} ^ {4'b0000, fb, fb, 2'b00};
    end
    return s;
  endfunction

  task automatic check(bit ok, string what, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %02h expected %02h", cur_tag, what, act, exp);
    end
  endtask

  // monitor: compare each consumed byte against the scoreboard
  initial forever begin
    @(negedge clk);
    if (tx_ack) begin
      if (expq.size() == 0) check(0, "unexpected byte", tx_byte, 8'hxx);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        check(tx_valid && tx_byte == e, "stream byte", tx_byte, e);
      end
    end
  end

  task automatic pulse_in(ref logic s);
    @(posedge clk); #1 s = 1'b1;
    @(posedge clk); #1 s = 1'b0;
  endtask

  task automatic put(logic [7:0] b);
    @(posedge clk); #1 rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  task automatic start_cmd(logic [7:0] cmd, logic [7:0] ta1, logic [7:0] ta2);
    pulse_in(bus_reset);
    pulse_in(cmd_start);
    put(cmd); put(ta1); put(ta2);
    repeat (3) @(posedge clk);
  endtask

  task automatic build(logic [7:0] cmd, logic [7:0] ta1, logic [7:0] ta2, int n);
    bit   msk, ones;
    int   a, last;
    logic [7:0] m1, m2, dc, b;
    msk = (cmd != 8'h65);
    m1 = msk ? (ta1 & 8'h7F) : ta1;
    m2 = msk ? 8'h00 : ta2;
    expq.push_back(crc_ref(crc_ref(crc_ref(8'h00, cmd), m1), m2));
    a = int'(m1);
    ones = (cmd == 8'h65) ? (ta2 != 0 || a > 159) : (cmd == 8'hAA) ? (a > 7) : 1'b0;
    last = (cmd == 8'h65) ? 159 : (cmd == 8'hAA) ? 7 : 127;
    dc = 8'h00;
    while (expq.size() < n) begin
      if (ones) expq.push_back(8'hFF);
      else begin
        b = (cmd == 8'hAA) ? st_f(a) : dat_f(a);
        expq.push_back(b);
        dc = crc_ref(dc, b);
        if (a == last || (cmd == 8'hC3 && (a % 32) == 31)) begin
          expq.push_back(dc);
          dc = 8'h00;
          if (cmd == 8'hC3 && a != 127) a++;
          else ones = 1'b1;
        end else a++;
      end
    end
    while (expq.size() > n) void'(expq.pop_back());
  endtask

  task automatic run(logic [7:0] cmd, logic [7:0] ta1, logic [7:0] ta2, int n, string tag);
    cur_tag = tag;
    build(cmd, ta1, ta2, n);
    start_cmd(cmd, ta1, ta2);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tx_ack = 1'b1;
      @(posedge clk); #1 tx_ack = 1'b0;
      repeat (3) @(posedge clk);
    end
    @(negedge clk);
    check(expq.size() == 0, "bytes left unsent", 8'(expq.size()), 8'h00);
    expq.delete();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired: got 01 expected 00");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    cur_tag = "R1 reset";
    check(!tx_valid && !mem_rd, "idle after reset", {6'b0, tx_valid, mem_rd}, 8'h00);

    run(8'hF0, 8'h78, 8'h00, 12,  "R2 R3 F0 near page3 end");
    run(8'hF0, 8'h85, 8'h00, 126, "R7 R3 F0 filtered 0085");
    run(8'hC3, 8'h3C, 8'h00, 74,  "R4 C3 page crossings");
    run(8'hC3, 8'h9E, 8'h01, 6,   "R7 R4 C3 filtered 019E");
    run(8'h65, 8'h98, 8'h00, 12,  "R5 65 array end");
    run(8'h65, 8'hA0, 8'h00, 4,   "R5 65 reserved 00A0");
    run(8'h65, 8'h05, 8'h01, 4,   "R5 65 high byte set");
    run(8'hAA, 8'h03, 8'h00, 8,   "R6 AA status");
    run(8'hAA, 8'h85, 8'h00, 5,   "R7 R6 AA filtered 0085");
    run(8'hAA, 8'h10, 8'h00, 3,   "R6 AA beyond status");

    run(8'hF0, 8'h10, 8'h00, 3,   "R8 F0 partial");
    cur_tag = "R1 bus reset";
    pulse_in(bus_reset);
    @(negedge clk);
    check(!tx_valid, "tx_valid after bus reset", {7'b0, tx_valid}, 8'h00);
    run(8'hC3, 8'h1E, 8'h00, 5,   "R1 R4 after bus reset");

    cur_tag = "R9 unknown command";
    start_cmd(8'h0F, 8'h00, 8'h00);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!tx_valid && !mem_rd, "idle on unknown cmd", {6'b0, tx_valid, mem_rd}, 8'h00);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule